// File: doc/BRIEF.md
# DMA Transfer Queue Control Registers

This block is the software-facing front end of a single-channel DMA engine. Software programs the parameters of a transfer through a simple register port: addresses, lengths, strides and a repeat flag. It then writes a submit register. Each submission is copied into a small hardware queue and gets a rotating transfer tag. The transfer engine takes queued transfers one at a time through a valid/ready handshake, and later reports each finished tag on a completion strobe.

Completions build up in a per-tag bitmask, so software can keep several transfers in flight and retire them in any order. Two interrupt causes exist. One reports that the queue has freed a slot because a transfer was handed to the engine. The other reports that at least one transfer has finished. Both causes are held in a pending register that software clears by writing ones, and are gated by a mask register. The data movers and address generation are outside this block.

Top module: `dmaq_ctrl`

## Requirements
- R1: After reset the mask register (0x80) reads 3, the pending register (0x84) reads 0, control (0x400) reads 0, the next-tag register (0x404) reads 0, the done mask (0x428) reads 0, status (0x430) reads 1 and `irq` is low.
- R2: Parameter registers read back what was written: destination 0x410, source 0x414, X length 0x418, Y length 0x41C, destination stride 0x420, source stride 0x424. Flags at 0x40C keep only bit 0, the repeat flag.
- R3: Writing a value with bit 0 set to 0x408 while control bit 0 (enable) is set and the queue is not full stores the current parameters in the queue. The next-tag register (0x404) then advances by one modulo 4.
- R4: Reading 0x408 returns 1 while 4 transfers are queued and 0 otherwise. A submission made while the queue is full or the block is disabled is dropped.
- R5: `xfer_valid` is high when enable is set, control bit 1 (hold) is clear and the queue is not empty. The `xfer_*` outputs then show the oldest queued transfer and its tag, in submission order. A cycle with `xfer_valid` and `xfer_ready` both high removes that transfer.
- R6: A `done_valid` pulse sets bit `done_id` of the done mask (0x428). That bit clears when the same tag is given to a new submission.
- R7: Pending bit 0 sets on every handoff to the engine and bit 1 sets on every completion. Writing ones to 0x84 clears those bits. A new event wins over a clear made in the same cycle.
- R8: `irq` is high when any pending bit is set while its mask bit is 0. Register 0x88 reads pending AND NOT mask.
- R9: Writing control with bit 0 clear empties the queue, drops `xfer_valid` and clears the busy state. Tag numbering continues from where it was.
- R10: 0x42C reads the tag of the oldest queued transfer, which equals the next tag when the queue is empty. Status 0x430 bit 0 means the queue is empty. Bit 1 means busy: the queue is not empty, or handed-off transfers have not yet completed.
- R11: 0x434 and 0x438 return the engine's current source and destination address inputs. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| xfer_valid | output | 1 | Queued transfer offered to the engine |
| xfer_ready | input | 1 | Engine accepts the offered transfer |
| xfer_id | output | ID_W | Tag of the offered transfer |
| xfer_dst | output | DATA_W | Destination address |
| xfer_src | output | DATA_W | Source address |
| xfer_xlen | output | DATA_W | X length field as programmed |
| xfer_ylen | output | DATA_W | Y length field as programmed |
| xfer_dst_stride | output | DATA_W | Destination stride |
| xfer_src_stride | output | DATA_W | Source stride |
| xfer_cyclic | output | 1 | Repeat flag |
| done_valid | input | 1 | Engine reports a finished transfer |
| done_id | input | ID_W | Tag of the finished transfer |
| cur_src | input | DATA_W | Engine's current source address |
| cur_dst | input | DATA_W | Engine's current destination address |

## Verification
A wrong queue pointer shows on the `xfer_*` outputs at the next handoff, as a transfer with the wrong length or tag, or as one that is lost or repeated. The handoff-tag counter is kept apart from the queue pointers. If the two diverge, 0x42C and `xfer_id` disagree with the order of submission in the very next cycle. An interrupt-state fault shows as a pending read or an `irq` level that is wrong one cycle after the event, the clear write or the mask write that caused it.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
   localparam logic [11:0] OFS_IMASK  = 12'h080;
   localparam logic [11:0] OFS_IPEND  = 12'h084;
   localparam logic [11:0] OFS_ISRC   = 12'h088;
   localparam logic [11:0] OFS_CTRL   = 12'h400;
   localparam logic [11:0] OFS_NEXTID = 12'h404;
   localparam logic [11:0] OFS_SUBMIT = 12'h408;
   localparam logic [11:0] OFS_FLAGS  = 12'h40C;
   localparam logic [11:0] OFS_DST    = 12'h410;
   localparam logic [11:0] OFS_SRC    = 12'h414;
   localparam logic [11:0] OFS_XLEN   = 12'h418;
   localparam logic [11:0] OFS_YLEN   = 12'h41C;
   localparam logic [11:0] OFS_DSTR   = 12'h420;
   localparam logic [11:0] OFS_SSTR   = 12'h424;
   localparam logic [11:0] OFS_DONE   = 12'h428;
   localparam logic [11:0] OFS_HEAD   = 12'h42C;
   localparam logic [11:0] OFS_STAT   = 12'h430;
   localparam logic [11:0] OFS_CSRC   = 12'h434;
   localparam logic [11:0] OFS_CDST   = 12'h438;

   localparam int IRQ_SLOT = 0;
   localparam int IRQ_FIN  = 1;
   localparam int IRQ_N    = 2;
   localparam int CTL_EN   = 0;
   localparam int CTL_HOLD = 1;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   input  logic         flush,
   output logic [W-1:0] head_data,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign head_data = mem[rd_ptr];
   assign empty     = (cnt == '0);
   assign full      = (cnt == CNT_W'(DEPTH));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/dmaq_tracker.sv
module dmaq_tracker #(
   parameter int ID_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 submit,
   input  logic                 handoff,
   input  logic                 flush,
   input  logic                 done_valid,
   input  logic [ID_W-1:0]      done_id,
   output logic [ID_W-1:0]      next_id,
   output logic [ID_W-1:0]      head_id,
   output logic [(1<<ID_W)-1:0] done_mask,
   output logic                 inflight
);
   localparam int NSLOT = 1 << ID_W;
   localparam int OUT_W = ID_W + 2;

   logic [OUT_W-1:0] out_cnt;
   logic [NSLOT-1:0] mask_n;

   always_comb begin
      mask_n = done_mask;
      if (submit)     mask_n[next_id] = 1'b0;
      if (done_valid) mask_n[done_id] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_id   <= '0;
         head_id   <= '0;
         done_mask <= '0;
         out_cnt   <= '0;
      end else begin
         done_mask <= mask_n;
         if (submit) next_id <= next_id + 1'b1;
         if (flush)        head_id <= next_id;
         else if (handoff) head_id <= head_id + 1'b1;
         if (flush) out_cnt <= '0;
         else if (handoff && !done_valid && out_cnt != '1) out_cnt <= out_cnt + OUT_W'(1);
         else if (!handoff && done_valid && out_cnt != '0) out_cnt <= out_cnt - OUT_W'(1);
      end
   end

   assign inflight = (out_cnt != '0);

   // R6
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> done_mask[$past(done_id)]);
   // R6
   reuse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (submit && !(done_valid && done_id == next_id)) |=> !done_mask[$past(next_id)]);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
   parameter int N       = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr_we,
   input  logic         mask_we,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] pending,
   output logic [N-1:0] mask,
   output logic         irq
);
   logic [N-1:0] clr_vec;
   logic         irq_raw;

   assign clr_vec = clr_we ? wbits : '0;
   assign irq_raw = |(pending & ~mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= '0;
         mask    <= '1;
      end else begin
         pending <= (pending & ~clr_vec) | evt;
         if (mask_we) mask <= wbits;
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = irq_raw;
      end
   endgenerate

   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pending) & ~$past(clr_vec)) & ~pending) == '0));
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pending & $past(evt)) == $past(evt)));
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int QDEPTH  = 4,
   parameter bit IRQ_REG = 1'b0,
   parameter int ID_W    = $clog2(QDEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ID_W-1:0]   xfer_id,
   output logic [DATA_W-1:0] xfer_dst,
   output logic [DATA_W-1:0] xfer_src,
   output logic [DATA_W-1:0] xfer_xlen,
   output logic [DATA_W-1:0] xfer_ylen,
   output logic [DATA_W-1:0] xfer_dst_stride,
   output logic [DATA_W-1:0] xfer_src_stride,
   output logic              xfer_cyclic,
   input  logic              done_valid,
   input  logic [ID_W-1:0]   done_id,
   input  logic [DATA_W-1:0] cur_src,
   input  logic [DATA_W-1:0] cur_dst
);
   import dmaq_pkg::*;

   localparam int DESC_W = 6 * DATA_W + 1;
   localparam int NSLOT  = 1 << ID_W;

   generate
      if (QDEPTH < 2 || (QDEPTH & (QDEPTH - 1)) != 0 || NSLOT != QDEPTH) begin : g_bad_depth
         $error("QDEPTH must be a power of two of at least 2");
      end
      if (DATA_W < NSLOT || DATA_W < 8) begin : g_bad_width
         $error("DATA_W too narrow for the done mask");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must cover the register map");
      end
   endgenerate

   logic              ctl_en, ctl_hold, flg_cyc;
   logic [DATA_W-1:0] p_dst, p_src, p_xlen, p_ylen, p_dstr, p_sstr;
   logic              q_empty, q_full, submit, flush, handoff, inflight;
   logic [DESC_W-1:0] push_desc, head_desc;
   logic [ID_W-1:0]   next_id, head_id;
   logic [NSLOT-1:0]  done_mask;
   logic [IRQ_N-1:0]  pend, imask, evt;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign submit  = reg_wr && hit(reg_addr, OFS_SUBMIT) && reg_wdata[0] && ctl_en && !q_full;
   assign flush   = reg_wr && hit(reg_addr, OFS_CTRL) && !reg_wdata[CTL_EN];
   assign xfer_valid = ctl_en && !ctl_hold && !q_empty;
   assign handoff = xfer_valid && xfer_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_en <= 1'b0; ctl_hold <= 1'b0; flg_cyc <= 1'b0;
         p_dst <= '0; p_src <= '0; p_xlen <= '0;
         p_ylen <= '0; p_dstr <= '0; p_sstr <= '0;
      end else if (reg_wr) begin
         if (hit(reg_addr, OFS_CTRL)) begin
            ctl_en   <= reg_wdata[CTL_EN];
            ctl_hold <= reg_wdata[CTL_HOLD];
         end
         if (hit(reg_addr, OFS_FLAGS)) flg_cyc <= reg_wdata[0];
         if (hit(reg_addr, OFS_DST))   p_dst   <= reg_wdata;
         if (hit(reg_addr, OFS_SRC))   p_src   <= reg_wdata;
         if (hit(reg_addr, OFS_XLEN))  p_xlen  <= reg_wdata;
         if (hit(reg_addr, OFS_YLEN))  p_ylen  <= reg_wdata;
         if (hit(reg_addr, OFS_DSTR))  p_dstr  <= reg_wdata;
         if (hit(reg_addr, OFS_SSTR))  p_sstr  <= reg_wdata;
      end
   end

   assign push_desc = {flg_cyc, p_sstr, p_dstr, p_ylen, p_xlen, p_src, p_dst};
   assign {xfer_cyclic, xfer_src_stride, xfer_dst_stride,
           xfer_ylen, xfer_xlen, xfer_src, xfer_dst} = head_desc;
   assign xfer_id = head_id;

   dmaq_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) i_queue (
      .clk(clk), .rst_n(rst_n), .push(submit), .push_data(push_desc),
      .pop(handoff), .flush(flush), .head_data(head_desc),
      .empty(q_empty), .full(q_full));

   dmaq_tracker #(.ID_W(ID_W)) i_tracker (
      .clk(clk), .rst_n(rst_n), .submit(submit), .handoff(handoff),
      .flush(flush), .done_valid(done_valid), .done_id(done_id),
      .next_id(next_id), .head_id(head_id), .done_mask(done_mask),
      .inflight(inflight));

   always_comb begin
      evt = '0;
      evt[IRQ_SLOT] = handoff;
      evt[IRQ_FIN]  = done_valid;
   end

   dmaq_irq #(.N(IRQ_N), .REG_OUT(IRQ_REG)) i_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .clr_we(reg_wr && hit(reg_addr, OFS_IPEND)),
      .mask_we(reg_wr && hit(reg_addr, OFS_IMASK)),
      .wbits(reg_wdata[IRQ_N-1:0]), .pending(pend), .mask(imask), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_IMASK):  reg_rdata = DATA_W'(imask);
         ADDR_W'(OFS_IPEND):  reg_rdata = DATA_W'(pend);
         ADDR_W'(OFS_ISRC):   reg_rdata = DATA_W'(pend & ~imask);
         ADDR_W'(OFS_CTRL):   reg_rdata = DATA_W'({ctl_hold, ctl_en});
         ADDR_W'(OFS_NEXTID): reg_rdata = DATA_W'(next_id);
         ADDR_W'(OFS_SUBMIT): reg_rdata = DATA_W'(q_full);
         ADDR_W'(OFS_FLAGS):  reg_rdata = DATA_W'(flg_cyc);
         ADDR_W'(OFS_DST):    reg_rdata = p_dst;
         ADDR_W'(OFS_SRC):    reg_rdata = p_src;
         ADDR_W'(OFS_XLEN):   reg_rdata = p_xlen;
         ADDR_W'(OFS_YLEN):   reg_rdata = p_ylen;
         ADDR_W'(OFS_DSTR):   reg_rdata = p_dstr;
         ADDR_W'(OFS_SSTR):   reg_rdata = p_sstr;
         ADDR_W'(OFS_DONE):   reg_rdata = DATA_W'(done_mask);
         ADDR_W'(OFS_HEAD):   reg_rdata = DATA_W'(head_id);
         ADDR_W'(OFS_STAT):   reg_rdata = DATA_W'({inflight || !q_empty, q_empty});
         ADDR_W'(OFS_CSRC):   reg_rdata = cur_src;
         ADDR_W'(OFS_CDST):   reg_rdata = cur_dst;
         default:             reg_rdata = '0;
      endcase
   end

   // R7
   handoff_sot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |=> pend[IRQ_SLOT]);
   // R5
   offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready && !flush) |=> $stable(xfer_id));
   // R10
   empty_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |-> (head_id == next_id));
   // R9
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!xfer_valid && q_empty));
endmodule

// File: tb/test_dmaq_ctrl.sv
module test_dmaq_ctrl;
   localparam int DW = 32;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq, xfer_valid, xfer_cyclic;
   logic          xfer_ready = 1'b0;
   logic [1:0]    xfer_id;
   logic [DW-1:0] xfer_dst, xfer_src, xfer_xlen, xfer_ylen, xfer_dst_stride, xfer_src_stride;
   logic          done_valid = 1'b0;
   logic [1:0]    done_id = '0;
   logic [DW-1:0] cur_src = '0, cur_dst = '0;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dmaq_ctrl i_dmaq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_id(xfer_id),
      .xfer_dst(xfer_dst), .xfer_src(xfer_src), .xfer_xlen(xfer_xlen),
      .xfer_ylen(xfer_ylen), .xfer_dst_stride(xfer_dst_stride),
      .xfer_src_stride(xfer_src_stride), .xfer_cyclic(xfer_cyclic),
      .done_valid(done_valid), .done_id(done_id),
      .cur_src(cur_src), .cur_dst(cur_dst));

   // {address, write data, expected readback}
   localparam logic [AW+2*DW-1:0] VEC [7] = '{
      {12'h410, 32'h1234_5678, 32'h1234_5678},
      {12'h414, 32'h89AB_CDEF, 32'h89AB_CDEF},
      {12'h418, 32'h0000_003F, 32'h0000_003F},
      {12'h41C, 32'h0000_0007, 32'h0000_0007},
      {12'h420, 32'h0000_0100, 32'h0000_0100},
      {12'h424, 32'h0000_0200, 32'h0000_0200},
      {12'h40C, 32'hFFFF_FFFF, 32'h0000_0001}
   };

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic take(input string tag, input logic [1:0] id, input logic [DW-1:0] xlen);
      @(negedge clk);
      chk(tag, {31'd0, xfer_valid}, 32'd1);
      chk(tag, {30'd0, xfer_id}, {30'd0, id});
      chk(tag, xfer_xlen, xlen);
      xfer_ready = 1'b1;
      @(negedge clk);
      xfer_ready = 1'b0;
   endtask

   task automatic finish_pulse(input logic [1:0] id);
      @(negedge clk);
      done_valid = 1'b1; done_id = id;
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd("R1", 12'h080, 32'd3);
      rd("R1", 12'h084, 32'd0);
      rd("R1", 12'h400, 32'd0);
      rd("R1", 12'h404, 32'd0);
      rd("R1", 12'h428, 32'd0);
      rd("R1", 12'h430, 32'd1);
      chk("R1", {31'd0, irq}, 32'd0);

      // R2 parameter table
      for (int i = 0; i < 7; i++) begin
         wr(VEC[i][AW+2*DW-1:2*DW], VEC[i][2*DW-1:DW]);
         rd("R2", VEC[i][AW+2*DW-1:2*DW], VEC[i][DW-1:0]);
      end

      // R4 submission while disabled is dropped
      wr(12'h408, 32'd1);
      rd("R4", 12'h430, 32'd1);
      rd("R4", 12'h404, 32'd0);

      // R3 fill the queue while held
      wr(12'h400, 32'd3);
      for (int i = 0; i < 4; i++) begin
         wr(12'h418, 32'(10 + i));
         wr(12'h408, 32'd1);
         rd("R3", 12'h404, 32'((i + 1) % 4));
      end
      rd("R4", 12'h408, 32'd1);
      wr(12'h418, 32'd99);
      wr(12'h408, 32'd1);
      rd("R10", 12'h42C, 32'd0);
      chk("R5", {31'd0, xfer_valid}, 32'd0);

      // R5 release hold, first handoff
      wr(12'h400, 32'd1);
      @(negedge clk);
      chk("R5", xfer_src, 32'h89AB_CDEF);
      chk("R5", {31'd0, xfer_cyclic}, 32'd1);
      take("R5", 2'd0, 32'd10);
      rd("R7", 12'h084, 32'd1);
      rd("R4", 12'h408, 32'd0);
      rd("R10", 12'h42C, 32'd1);
      chk("R8", {31'd0, irq}, 32'd0);
      wr(12'h080, 32'd0);
      @(negedge clk);
      chk("R8", {31'd0, irq}, 32'd1);
      rd("R8", 12'h088, 32'd1);
      wr(12'h084, 32'd1);
      rd("R7", 12'h084, 32'd0);
      chk("R8", {31'd0, irq}, 32'd0);
      for (int i = 1; i < 4; i++) take("R5", 2'(i), 32'(10 + i));
      @(negedge clk);
      chk("R4", {31'd0, xfer_valid}, 32'd0);
      rd("R10", 12'h430, 32'd3);

      // R6 out-of-order completions
      finish_pulse(2'd2);
      rd("R6", 12'h428, 32'd4);
      rd("R7", 12'h084, 32'd3);
      wr(12'h084, 32'd3);
      rd("R7", 12'h084, 32'd0);
      finish_pulse(2'd0);
      finish_pulse(2'd1);
      finish_pulse(2'd3);
      rd("R6", 12'h428, 32'hF);
      rd("R10", 12'h430, 32'd1);
      wr(12'h084, 32'd3);

      // R6 tag reuse clears its done bit
      wr(12'h408, 32'd1);
      rd("R6", 12'h428, 32'hE);
      rd("R3", 12'h404, 32'd1);

      // R8 partial mask
      wr(12'h080, 32'd2);
      take("R8", 2'd0, 32'd99);
      rd("R8", 12'h084, 32'd1);
      chk("R8", {31'd0, irq}, 32'd1);
      rd("R8", 12'h088, 32'd1);
      wr(12'h084, 32'd1);
      finish_pulse(2'd0);
      rd("R8", 12'h084, 32'd2);
      chk("R8", {31'd0, irq}, 32'd0);
      rd("R8", 12'h088, 32'd0);
      rd("R6", 12'h428, 32'hF);
      wr(12'h084, 32'd2);

      // R9 disable abandons queued work
      wr(12'h400, 32'd3);
      wr(12'h408, 32'd1);
      wr(12'h408, 32'd1);
      rd("R10", 12'h430, 32'd2);
      wr(12'h400, 32'd0);
      rd("R9", 12'h430, 32'd1);
      chk("R9", {31'd0, xfer_valid}, 32'd0);
      rd("R9", 12'h404, 32'd3);
      rd("R10", 12'h42C, 32'd3);
      wr(12'h400, 32'd1);
      @(negedge clk);
      chk("R9", {31'd0, xfer_valid}, 32'd0);

      // R7 event wins over same-cycle clear
      wr(12'h408, 32'd1);
      @(negedge clk);
      chk("R5", {30'd0, xfer_id}, 32'd3);
      xfer_ready = 1'b1; reg_wr = 1'b1; reg_addr = 12'h084; reg_wdata = 32'd1;
      @(negedge clk);
      xfer_ready = 1'b0; reg_wr = 1'b0;
      rd("R7", 12'h084, 32'd1);
      chk("R8", {31'd0, irq}, 32'd1);

      // R11 pass-through and unmapped
      cur_src = 32'hAAAA_5555; cur_dst = 32'h0F0F_0F0F;
      rd("R11", 12'h434, 32'hAAAA_5555);
      rd("R11", 12'h438, 32'h0F0F_0F0F);
      rd("R11", 12'h100, 32'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule